// File: doc/BRIEF.md
# Two-Level Ring Coherence Directory Cell

This cell sits where a ring of processor caches meets a ring of directory cells one level higher. Both rings move packets one way only. Every packet that reaches the cell from either ring is looked up in a directory. The directory keeps one entry per page, and each entry holds a 2-bit coherence state for each 128-byte subpage of that page. From the packet's type, its source node, its access kind and the directory state, the cell sends the packet on along the lower ring or along the upper ring. In the same cycle it writes the new subpage state back, so the packet directly behind sees the update.

There is no home memory. A local miss for a subpage that no cache on this ring holds is lifted to the upper ring, and the subpage is marked pending until the answer comes back down. A request passing on the upper ring is taken down only when a cache on this ring holds the subpage. Responses retrace the same path back to the requesting ring. Each ring port uses a valid/ready handshake, and each output is a single register.

Top module: `ring_dir_router`

## Requirements
- R1: While reset is high, and in the first cycle after it, both outputs are not valid. After reset every subpage of every page reads as invalid. States are encoded as 0 invalid, 1 shared, 2 exclusive, 3 pending.
- R2: A request arriving on the lower input whose source ring field equals HOME_RING, for a subpage in the invalid state, goes to the upper output, and the subpage becomes pending.
- R3: A request from this ring for a pending subpage goes unchanged to the lower output, and the subpage state stays the same.
- R4: A request from this ring for a shared or exclusive subpage goes to the lower output. The subpage becomes exclusive when the kind bit is 1 (read-exclusive) and shared when it is 0 (read-shared).
- R5: A request on the upper input for a subpage held shared or exclusive goes to the lower output. The subpage becomes invalid for read-exclusive and shared for read-shared.
- R6: A request on the upper input for an invalid or pending subpage goes to the upper output, and the subpage state stays the same.
- R7: A response on the upper input whose source ring field equals HOME_RING goes to the lower output, and the subpage becomes exclusive (kind 1) or shared (kind 0). Any other upper response goes to the upper output with no state change.
- R8: On the lower input, a response goes to the lower output when its source ring is HOME_RING and to the upper output otherwise. A request whose source ring is not HOME_RING goes to the upper output. Neither case changes any state.
- R9: Every accepted packet appears unmodified on exactly one output, valid in the cycle after acceptance. The packet layout is: bit 16 is the type (1 = response), bit 15 is the kind, bits 14:13 are the source ring, bits 12:10 are the source node, bits 9:4 are the page and bits 3:0 are the subpage.
- R10: At most one packet is accepted per cycle. When both inputs are valid, the upper input is served first and the lower input is stalled.
- R11: An output that is valid and not ready holds its packet stable, and any input whose packet is bound for that output is stalled.
- R12: Two packets to the same subpage accepted on consecutive cycles are routed so that the second sees the state written by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_in_vld | input | 1 | Lower ring input packet valid |
| lo_in_rdy | output | 1 | Lower ring input accepted this cycle |
| lo_in_pkt | input | 17 | Lower ring input packet |
| up_in_vld | input | 1 | Upper ring input packet valid |
| up_in_rdy | output | 1 | Upper ring input accepted this cycle |
| up_in_pkt | input | 17 | Upper ring input packet |
| lo_out_vld | output | 1 | Lower ring output packet valid |
| lo_out_rdy | input | 1 | Next lower ring stage can take a packet |
| lo_out_pkt | output | 17 | Lower ring output packet |
| up_out_vld | output | 1 | Upper ring output packet valid |
| up_out_rdy | input | 1 | Next upper ring stage can take a packet |
| up_out_pkt | output | 17 | Upper ring output packet |

## Verification
Random packets are drawn over a handful of pages and subpages, so the same subpage moves through invalid, pending, shared and exclusive under requests and responses from both rings and from home and foreign sources. Each routing rule is therefore hit from every state. Directed cases cover the remaining orderings. Two back-to-back requests to a fresh subpage separate a directory updated in the same cycle from a stale read. Both inputs valid at once separates upper-first service from lower-first. A held output with a second packet waiting separates correct stalling from overwriting.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2,
    ST_PND = 2'd3
  } sp_state_e;
endpackage

// File: rtl/hrd_dir_store.sv
module hrd_dir_store #(
  parameter int PAGE_W = 6,
  parameter int SUB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] page,
  input  logic [SUB_W-1:0]  sub,
  output logic [1:0]        cur_state,
  input  logic              wr_en,
  input  logic [1:0]        new_state
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int SUBS  = 1 << SUB_W;
  localparam int ROW_W = 2 * SUBS;

  logic [ROW_W-1:0] mem [PAGES];
  logic [PAGES-1:0] pg_vld;
  logic [ROW_W-1:0] rd_row;
  logic [ROW_W-1:0] wr_row;

  always_comb begin
    rd_row    = pg_vld[page] ? mem[page] : '0;
    cur_state = rd_row[sub*2 +: 2];
    wr_row    = rd_row;
    wr_row[sub*2 +: 2] = new_state;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[page] <= wr_row;
  end

  always_ff @(posedge clk) begin
    if (rst) pg_vld <= '0;
    else if (wr_en) pg_vld[page] <= 1'b1;
  end
endmodule

// File: rtl/hrd_route.sv
module hrd_route
  import hrd_pkg::*;
#(
  parameter int RING_W    = 2,
  parameter int HOME_RING = 1
) (
  input  logic              from_up,
  input  logic              is_rsp,
  input  logic              excl,
  input  logic [RING_W-1:0] src_ring,
  input  logic [1:0]        cur_state,
  output logic              to_up,
  output logic              upd,
  output logic [1:0]        new_state
);
  logic home;
  sp_state_e cs;

  always_comb begin
    home      = (src_ring == RING_W'(HOME_RING));
    cs        = sp_state_e'(cur_state);
    to_up     = 1'b0;
    upd       = 1'b0;
    new_state = cur_state;
    if (!from_up) begin
      if (is_rsp || !home) begin
        to_up = !home;
      end else begin
        unique case (cs)
          ST_INV: begin to_up = 1'b1; upd = 1'b1; new_state = ST_PND; end
          ST_PND: to_up = 1'b0;
          default: begin
            upd       = 1'b1;
            new_state = excl ? ST_EXC : ST_SHR;
          end
        endcase
      end
    end else if (is_rsp) begin
      to_up = !home;
      if (home) begin
        upd       = 1'b1;
        new_state = excl ? ST_EXC : ST_SHR;
      end
    end else begin
      if (cs == ST_SHR || cs == ST_EXC) begin
        upd       = 1'b1;
        new_state = excl ? ST_INV : ST_SHR;
      end else begin
        to_up = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hrd_out_slot.sv
module hrd_out_slot #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         free,
  output logic         vld,
  input  logic         rdy,
  output logic [W-1:0] dout
);
  assign free = !vld || rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (load) begin
      vld  <= 1'b1;
      dout <= din;
    end else if (rdy) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_dir_router.sv
module ring_dir_router #(
  parameter int RING_W    = 2,
  parameter int LOC_W     = 3,
  parameter int PAGE_W    = 6,
  parameter int SUB_W     = 4,
  parameter int HOME_RING = 1,
  localparam int PKT_W    = 2 + RING_W + LOC_W + PAGE_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lo_in_vld,
  output logic             lo_in_rdy,
  input  logic [PKT_W-1:0] lo_in_pkt,
  input  logic             up_in_vld,
  output logic             up_in_rdy,
  input  logic [PKT_W-1:0] up_in_pkt,
  output logic             lo_out_vld,
  input  logic             lo_out_rdy,
  output logic [PKT_W-1:0] lo_out_pkt,
  output logic             up_out_vld,
  input  logic             up_out_rdy,
  output logic [PKT_W-1:0] up_out_pkt
);
  localparam int RING_LSB = SUB_W + PAGE_W + LOC_W;
  localparam int KIND_BIT = PKT_W - 2;
  localparam int TYPE_BIT = PKT_W - 1;

  logic             sel_up;
  logic [PKT_W-1:0] pkt;
  logic             sel_vld;
  logic [1:0]       cur_state;
  logic [1:0]       new_state;
  logic             to_up;
  logic             upd;
  logic             lo_free;
  logic             up_free;
  logic             tgt_free;
  logic             fire;

  assign sel_up   = up_in_vld;
  assign pkt      = sel_up ? up_in_pkt : lo_in_pkt;
  assign sel_vld  = sel_up ? up_in_vld : lo_in_vld;
  assign tgt_free = to_up ? up_free : lo_free;
  assign fire     = sel_vld && tgt_free;
  assign up_in_rdy = sel_up && tgt_free;
  assign lo_in_rdy = !sel_up && tgt_free;

  hrd_dir_store #(.PAGE_W(PAGE_W), .SUB_W(SUB_W)) u_dir (
    .clk(clk), .rst(rst),
    .page(pkt[SUB_W +: PAGE_W]), .sub(pkt[SUB_W-1:0]),
    .cur_state(cur_state), .wr_en(fire && upd), .new_state(new_state)
  );

  hrd_route #(.RING_W(RING_W), .HOME_RING(HOME_RING)) u_route (
    .from_up(sel_up), .is_rsp(pkt[TYPE_BIT]), .excl(pkt[KIND_BIT]),
    .src_ring(pkt[RING_LSB +: RING_W]), .cur_state(cur_state),
    .to_up(to_up), .upd(upd), .new_state(new_state)
  );

  hrd_out_slot #(.W(PKT_W)) u_lo_slot (
    .clk(clk), .rst(rst), .load(fire && !to_up), .din(pkt), .free(lo_free),
    .vld(lo_out_vld), .rdy(lo_out_rdy), .dout(lo_out_pkt)
  );

  hrd_out_slot #(.W(PKT_W)) u_up_slot (
    .clk(clk), .rst(rst), .load(fire && to_up), .din(pkt), .free(up_free),
    .vld(up_out_vld), .rdy(up_out_rdy), .dout(up_out_pkt)
  );
endmodule

// File: rtl/hrd_checker.sv
module hrd_checker #(
  parameter int PKT_W     = 17,
  parameter int RING_LSB  = 13,
  parameter int RING_W    = 2,
  parameter int HOME_RING = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             lo_in_vld,
  input logic             lo_in_rdy,
  input logic [PKT_W-1:0] lo_in_pkt,
  input logic             up_in_vld,
  input logic             up_in_rdy,
  input logic [PKT_W-1:0] up_in_pkt,
  input logic             lo_out_vld,
  input logic             lo_out_rdy,
  input logic [PKT_W-1:0] lo_out_pkt,
  input logic             up_out_vld,
  input logic             up_out_rdy,
  input logic [PKT_W-1:0] up_out_pkt
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!lo_out_vld && !up_out_vld));

  assert_one_accept_R10: assert property (@(posedge clk) disable iff (rst)
    !(lo_in_vld && lo_in_rdy && up_in_vld && up_in_rdy));

  assert_upper_first_R10: assert property (@(posedge clk) disable iff (rst)
    up_in_vld |-> !lo_in_rdy);

  assert_lo_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (lo_out_vld && !lo_out_rdy) |=> (lo_out_vld && $stable(lo_out_pkt)));

  assert_up_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (up_out_vld && !up_out_rdy) |=> (up_out_vld && $stable(up_out_pkt)));

  assert_forward_R9: assert property (@(posedge clk) disable iff (rst)
    (up_in_vld && up_in_rdy) |=>
      ((lo_out_vld && lo_out_pkt == $past(up_in_pkt)) ||
       (up_out_vld && up_out_pkt == $past(up_in_pkt))));

  assert_foreign_lift_R8: assert property (@(posedge clk) disable iff (rst)
    (lo_in_vld && lo_in_rdy && lo_in_pkt[RING_LSB +: RING_W] != RING_W'(HOME_RING)) |=>
      (up_out_vld && up_out_pkt == $past(lo_in_pkt)));
endmodule

bind ring_dir_router hrd_checker #(
  .PKT_W(PKT_W), .RING_LSB(RING_LSB), .RING_W(RING_W), .HOME_RING(HOME_RING)
) u_chk (.*);

// File: tb/ring_dir_router_test.sv
`timescale 1ns/1ps
module ring_dir_router_test;
  localparam int HOME = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lo_in_vld = 1'b0, up_in_vld = 1'b0;
  logic lo_out_rdy = 1'b1, up_out_rdy = 1'b1;
  logic [16:0] lo_in_pkt = '0, up_in_pkt = '0;
  logic lo_in_rdy, up_in_rdy, lo_out_vld, up_out_vld;
  logic [16:0] lo_out_pkt, up_out_pkt;

  int checks = 0;
  int fails = 0;
  logic [1:0] mdl [64][16];

  always #4 clk = ~clk;

  ring_dir_router #(.HOME_RING(HOME)) uut (.*);

  function automatic logic [16:0] mk(bit rsp, bit ex, int ring, int loc, int page, int sub);
    return {rsp, ex, 2'(ring), 3'(loc), 6'(page), 4'(sub)};
  endfunction

  function automatic void model(input bit from_up, input logic [16:0] p, input logic [1:0] st,
                                output bit to_up, output logic [1:0] nst, output string tag);
    bit rsp = p[16];
    bit ex  = p[15];
    bit home = (p[14:13] == 2'(HOME));
    nst = st;
    if (!from_up) begin
      if (rsp || !home) begin to_up = !home; tag = "R8"; end
      else if (st == 2'd0) begin to_up = 1; nst = 2'd3; tag = "R2"; end
      else if (st == 2'd3) begin to_up = 0; tag = "R3"; end
      else begin to_up = 0; nst = ex ? 2'd2 : 2'd1; tag = "R4"; end
    end else if (rsp) begin
      to_up = !home; tag = "R7";
      if (home) nst = ex ? 2'd2 : 2'd1;
    end else if (st == 2'd1 || st == 2'd2) begin
      to_up = 0; nst = ex ? 2'd0 : 2'd1; tag = "R5";
    end else begin
      to_up = 1; tag = "R6";
    end
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(bit from_up, logic [16:0] p);
    bit to_up;
    logic [1:0] nst;
    string tag;
    @(negedge clk);
    if (from_up) begin up_in_vld = 1; up_in_pkt = p; end
    else begin lo_in_vld = 1; lo_in_pkt = p; end
    #1;
    model(from_up, p, mdl[p[9:4]][p[3:0]], to_up, nst, tag);
    chk((from_up ? up_in_rdy : lo_in_rdy) == 1'b1, tag, "input ready", 0, 1);
    @(posedge clk);
    mdl[p[9:4]][p[3:0]] = nst;
    @(negedge clk);
    up_in_vld = 0; lo_in_vld = 0;
    if (to_up)
      chk(up_out_vld && !lo_out_vld && up_out_pkt == p, tag, "routed up (R9)",
          {15'd0, up_out_vld, up_out_pkt}, {15'd0, 1'b1, p});
    else
      chk(lo_out_vld && !up_out_vld && lo_out_pkt == p, tag, "routed down (R9)",
          {15'd0, lo_out_vld, lo_out_pkt}, {15'd0, 1'b1, p});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [16:0] a, b;
    for (int i = 0; i < 64; i++) for (int j = 0; j < 16; j++) mdl[i][j] = 2'd0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!lo_out_vld && !up_out_vld, "R1", "outputs idle in reset", {lo_out_vld, up_out_vld}, 0);
    rst = 0;
    @(negedge clk);
    chk(!lo_out_vld && !up_out_vld, "R1", "outputs idle after reset", {lo_out_vld, up_out_vld}, 0);

    // R1/R2: fresh subpage after reset is invalid and gets lifted
    send(0, mk(0, 0, HOME, 2, 50, 9));
    // R3: now pending, passes lower ring
    send(0, mk(0, 1, HOME, 3, 50, 9));
    // R7: response comes back for home ring, grants exclusive
    send(1, mk(1, 1, HOME, 2, 50, 9));
    // R5: upper request takes it exclusive, invalidates
    send(1, mk(0, 1, 0, 1, 50, 9));
    // R6: upper request for invalid passes upper ring
    send(1, mk(0, 0, 2, 1, 50, 9));

    // R12: back-to-back on same subpage
    a = mk(0, 1, HOME, 1, 40, 5);
    b = mk(0, 0, HOME, 4, 40, 5);
    @(negedge clk); lo_in_vld = 1; lo_in_pkt = a;
    @(negedge clk); lo_in_pkt = b;
    chk(up_out_vld && up_out_pkt == a, "R12", "first lifted", up_out_pkt, a);
    @(negedge clk); lo_in_vld = 0;
    chk(lo_out_vld && lo_out_pkt == b && !up_out_vld, "R12", "second sees pending", lo_out_pkt, b);
    mdl[40][5] = 2'd3;

    // R10: both inputs valid, upper served first
    a = mk(1, 0, 3, 0, 41, 1);
    b = mk(1, 0, HOME, 5, 41, 2);
    @(negedge clk); up_in_vld = 1; up_in_pkt = a; lo_in_vld = 1; lo_in_pkt = b;
    #1;
    chk(up_in_rdy && !lo_in_rdy, "R10", "upper first", {up_in_rdy, lo_in_rdy}, 2'b10);
    @(negedge clk); up_in_vld = 0;
    chk(up_out_vld && up_out_pkt == a && !lo_out_vld, "R10", "upper packet out", up_out_pkt, a);
    #1;
    chk(lo_in_rdy, "R10", "lower served next", lo_in_rdy, 1);
    @(negedge clk); lo_in_vld = 0;
    chk(lo_out_vld && lo_out_pkt == b, "R10", "lower packet out", lo_out_pkt, b);

    // R11: held output stalls packet bound for it
    up_out_rdy = 0;
    a = mk(1, 1, 0, 2, 42, 3);
    b = mk(0, 0, 2, 2, 42, 4);
    send(0, a);
    @(negedge clk); lo_in_vld = 1; lo_in_pkt = b;
    #1;
    chk(!lo_in_rdy, "R11", "stalled while held", lo_in_rdy, 0);
    @(negedge clk);
    chk(up_out_vld && up_out_pkt == a && !lo_in_rdy, "R11", "held stable", up_out_pkt, a);
    up_out_rdy = 1;
    #1;
    chk(lo_in_rdy, "R11", "released", lo_in_rdy, 1);
    @(negedge clk); lo_in_vld = 0;
    chk(up_out_vld && up_out_pkt == b, "R11", "next packet out", up_out_pkt, b);

    // random traffic over a small address set
    for (int n = 0; n < 600; n++) begin
      bit fu = $urandom_range(0, 1);
      a = mk($urandom_range(0, 1), $urandom_range(0, 1),
             ($urandom_range(0, 2) == 0) ? $urandom_range(0, 3) : HOME,
             $urandom_range(0, 7), $urandom_range(0, 2), $urandom_range(0, 3));
      send(fu, a);
    end

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule